// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the status byte of a small 8-bit processor core. Each cycle it can take one ALU operation, given as the two operands, the result the ALU produced, and an operation class. From these it decides which flags change and what their new values are. The flags are negative, zero, carry and half-carry. An interrupt-mask bit sits next to them and changes only on explicit set and clear commands. The whole byte can also be loaded from a value pulled off the stack when an interrupt returns.

The status byte is always visible on an 8-bit output, for reads and for pushing to the stack. Only five bits hold state. The top three bits are tied high. A reset is asynchronous and active low. It forces the interrupt mask on and leaves the four result flags as they were, so software must not assume their values after reset.

Top module: `status_flag_unit`

## Requirements
- R1: The status byte layout is: bits 7..5 read as 1, bit 4 = half-carry (H), bit 3 = interrupt mask (I), bit 2 = negative (N), bit 1 = zero (Z), bit 0 = carry (C).
- R2: While `rst_n` is low, I reads 1 without waiting for a clock. H, N, Z and C keep the values they had before reset.
- R3: Flags change only on a clock edge where `op_valid` is 1. The class codes are 0 = add, 1 = add with carry, 2 = logic, 3 = load/store, 4 = subtract, 5 = compare. Codes 6 and 7 change nothing.
- R4: For classes 0 to 5, N takes bit 7 of `alu_res`, and Z is 1 exactly when `alu_res` is zero.
- R5: For add and add with carry, C is the carry out of bit 7 of a + b + cin, and H is the carry from bit 3 into bit 4 of the same sum. cin is 0 for add and the current C for add with carry.
- R6: For subtract and compare, C is the unsigned borrow, which is 1 when a < b. H is unchanged.
- R7: For logic and load/store, C and H are unchanged.
- R8: When `restore_en` is 1, bits 4..0 are loaded from `restore_byte[4:0]` and bits 7..5 of `restore_byte` are ignored. A restore takes priority over an ALU operation and over mask commands in the same cycle.
- R9: `imask_set` makes I equal to 1 and `imask_clr` makes I equal to 0. When both are high, the set wins. ALU operations never change I.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (affects I only) |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_class | input | 3 | Operation class code (see R3) |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result used for N and Z |
| imask_set | input | 1 | Set the interrupt mask |
| imask_clr | input | 1 | Clear the interrupt mask |
| restore_en | input | 1 | Load the status byte from the stack value |
| restore_byte | input | 8 | Status byte pulled from the stack |
| status_byte | output | 8 | Current status byte |

## Verification
The bench targets the sums that sit right at the nibble and byte boundaries:
- 0x0F + 0x01 and 0xFF + 0x01 test the carry chain. A half-carry taken from the wrong bit, or a carry read from the truncated result, shows up here.
- 0x80 + 0x80 gives a byte carry with no nibble carry. It shows whether the two carries are computed separately.
- An add with carry that only crosses the nibble because of the incoming carry catches a design that ignores C as the carry-in.

Class-dependent behaviour is checked directly:
- Subtract and compare with equal and with swapped operands catch a borrow of the wrong polarity or a half-carry that a subtract should not touch.
- Logic, load and the two reserved codes show whether the design disturbs flags it should leave alone.

A reset in the middle of a run is checked while it is still asserted and again after it releases. A design that clears all flags, or that sets I only on a clock edge, fails here. Restore commands and mask commands are issued in the same cycle as an ALU operation to expose a wrong priority order. Restoring 0x00 and 0xE0 catches any upper bit that tracks the written byte.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int STAT_W = 8;
  localparam int IMPL_W = 5;
  localparam int FIX_W  = STAT_W - IMPL_W;

  localparam int POS_C = 0;
  localparam int POS_Z = 1;
  localparam int POS_N = 2;
  localparam int POS_I = 3;
  localparam int POS_H = 4;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADC   = 3'd1,
    OP_LOGIC = 3'd2,
    OP_LOAD  = 3'd3,
    OP_SUB   = 3'd4,
    OP_CMP   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic h;
    logic c;
  } add_carry_t;

  // Carries of a + b + cin: nibble boundary and byte boundary
  function automatic add_carry_t add_carries(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input logic              cin);
    logic [NIB_W:0]  lo;
    logic [DATA_W:0] full;
    add_carry_t      r;
    lo   = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    full = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    r.h  = lo[NIB_W];
    r.c  = full[DATA_W];
    return r;
  endfunction

  // Unsigned borrow of a - b
  function automatic logic sub_borrow(input logic [DATA_W-1:0] a,
                                      input logic [DATA_W-1:0] b);
    logic [DATA_W:0] diff;
    diff = {1'b0, a} - {1'b0, b};
    return diff[DATA_W];
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return (v == '0);
  endfunction

  function automatic logic is_neg(input logic [DATA_W-1:0] v);
    return v[DATA_W-1];
  endfunction
endpackage

// File: rtl/sfu_flag_eval.sv
module sfu_flag_eval
  import sfu_pkg::*;
(
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              c_now,
  output logic              upd_nz,
  output logic              upd_c,
  output logic              upd_h,
  output logic              nxt_n,
  output logic              nxt_z,
  output logic              nxt_c,
  output logic              nxt_h
);
  op_class_e  cls;
  logic       is_add, is_sub, is_nzonly;
  logic       add_cin;
  add_carry_t add_cy;
  logic       borrow;

  assign cls       = op_class_e'(op_class);
  assign is_add    = (cls == OP_ADD) || (cls == OP_ADC);
  assign is_sub    = (cls == OP_SUB) || (cls == OP_CMP);
  assign is_nzonly = (cls == OP_LOGIC) || (cls == OP_LOAD);
  assign add_cin   = (cls == OP_ADC) ? c_now : 1'b0;

  assign add_cy = add_carries(alu_a, alu_b, add_cin);
  assign borrow = sub_borrow(alu_a, alu_b);

  assign upd_nz = op_valid && (is_add || is_sub || is_nzonly);
  assign upd_c  = op_valid && (is_add || is_sub);
  assign upd_h  = op_valid && is_add;

  assign nxt_n = is_neg(alu_res);
  assign nxt_z = is_zero(alu_res);

  always_comb begin
    nxt_c = c_now;
    nxt_h = 1'b0;
    if (is_add) begin
      nxt_c = add_cy.c;
      nxt_h = add_cy.h;
    end else if (is_sub) begin
      nxt_c = borrow;
    end
  end
endmodule

// File: rtl/sfu_result_flags.sv
module sfu_result_flags
  import sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restore_en,
  input  logic [STAT_W-1:0] restore_byte,
  input  logic              upd_nz,
  input  logic              upd_c,
  input  logic              upd_h,
  input  logic              nxt_n,
  input  logic              nxt_z,
  input  logic              nxt_c,
  input  logic              nxt_h,
  input  logic [DATA_W-1:0] alu_res,
  output logic              flag_h,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c
);
  // No reset on purpose: a reset leaves these four flags untouched
  always_ff @(posedge clk) begin
    if (restore_en) begin
      flag_h <= restore_byte[POS_H];
      flag_n <= restore_byte[POS_N];
      flag_z <= restore_byte[POS_Z];
      flag_c <= restore_byte[POS_C];
    end else begin
      if (upd_h)  flag_h <= nxt_h;
      if (upd_c)  flag_c <= nxt_c;
      if (upd_nz) begin
        flag_n <= nxt_n;
        flag_z <= nxt_z;
      end
    end
  end

  a_r8_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> ({flag_h, flag_n, flag_z, flag_c} ==
                    {$past(restore_byte[POS_H]), $past(restore_byte[POS_N]),
                     $past(restore_byte[POS_Z]), $past(restore_byte[POS_C])}));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && !upd_nz && !upd_c && !upd_h)
      |=> $stable({flag_h, flag_n, flag_z, flag_c}));

  a_r4_zero_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && upd_nz) |=> (flag_z == ($past(alu_res) == '0)));

  a_r7_h_only_on_add: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && !upd_h) |=> $stable(flag_h));

  a_r7_c_kept_without_arith: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && !upd_c) |=> $stable(flag_c));
endmodule

// File: rtl/sfu_mask_ctrl.sv
module sfu_mask_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic restore_en,
  input  logic restore_bit,
  input  logic imask_set,
  input  logic imask_clr,
  output logic imask
);
  logic mask_cmd;
  assign mask_cmd = imask_set || imask_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          imask <= 1'b1;
    else if (restore_en) imask <= restore_bit;
    else if (imask_set)  imask <= 1'b1;
    else if (imask_clr)  imask <= 1'b0;
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && imask_set) |=> imask);

  a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && imask_clr && !imask_set) |=> !imask);

  a_r9_ops_keep_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && !mask_cmd) |=> $stable(imask));

  a_r8_restore_mask: assert property (@(posedge clk) disable iff (!rst_n)
    restore_en |=> (imask == $past(restore_bit)));
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_class,
  input  logic [DATA_W-1:0] alu_a,
  input  logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_res,
  input  logic              imask_set,
  input  logic              imask_clr,
  input  logic              restore_en,
  input  logic [STAT_W-1:0] restore_byte,
  output logic [STAT_W-1:0] status_byte
);
  logic upd_nz, upd_c, upd_h;
  logic nxt_n, nxt_z, nxt_c, nxt_h;
  logic flag_h, flag_n, flag_z, flag_c, flag_i;

  sfu_flag_eval u_eval (
    .op_valid (op_valid),
    .op_class (op_class),
    .alu_a    (alu_a),
    .alu_b    (alu_b),
    .alu_res  (alu_res),
    .c_now    (flag_c),
    .upd_nz   (upd_nz),
    .upd_c    (upd_c),
    .upd_h    (upd_h),
    .nxt_n    (nxt_n),
    .nxt_z    (nxt_z),
    .nxt_c    (nxt_c),
    .nxt_h    (nxt_h)
  );

  sfu_result_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .restore_en   (restore_en),
    .restore_byte (restore_byte),
    .upd_nz       (upd_nz),
    .upd_c        (upd_c),
    .upd_h        (upd_h),
    .nxt_n        (nxt_n),
    .nxt_z        (nxt_z),
    .nxt_c        (nxt_c),
    .nxt_h        (nxt_h),
    .alu_res      (alu_res),
    .flag_h       (flag_h),
    .flag_n       (flag_n),
    .flag_z       (flag_z),
    .flag_c       (flag_c)
  );

  sfu_mask_ctrl u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .restore_en  (restore_en),
    .restore_bit (restore_byte[POS_I]),
    .imask_set   (imask_set),
    .imask_clr   (imask_clr),
    .imask       (flag_i)
  );

  always_comb begin
    status_byte        = '1;
    status_byte[POS_H] = flag_h;
    status_byte[POS_I] = flag_i;
    status_byte[POS_N] = flag_n;
    status_byte[POS_Z] = flag_z;
    status_byte[POS_C] = flag_c;
  end

  a_r5_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && op_valid && (op_class == 3'd0) && (alu_a == 8'hFF) && (alu_b != 8'h00))
      |=> status_byte[POS_C]);

  a_r6_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (!restore_en && op_valid && ((op_class == 3'd4) || (op_class == 3'd5)) && (alu_a == alu_b))
      |=> !status_byte[POS_C]);
endmodule

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       op_valid = 1'b0;
  logic [2:0] op_class = 3'd0;
  logic [7:0] alu_a = 8'd0, alu_b = 8'd0, alu_res = 8'd0;
  logic       imask_set = 1'b0, imask_clr = 1'b0, restore_en = 1'b0;
  logic [7:0] restore_byte = 8'd0;
  logic [7:0] status_byte;

  int total = 0;
  int bad = 0;
  int m_h, m_i, m_n, m_z, m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res),
    .imask_set(imask_set), .imask_clr(imask_clr),
    .restore_en(restore_en), .restore_byte(restore_byte),
    .status_byte(status_byte)
  );

  function automatic logic [7:0] model_byte();
    return {3'b111, m_h[0], m_i[0], m_n[0], m_z[0], m_c[0]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: status actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, update the model, compare at the next negedge
  task automatic cyc(input string req, input bit v, input int cls, input int a, input int b,
                     input bit ms, input bit mc, input bit rs, input int rb);
    int cin, tot, res;
    cin = (cls == 1) ? m_c : 0;
    case (cls)
      0, 1:    res = (a + b + cin) % 256;
      2:       res = a & b;
      3:       res = b;
      4, 5:    res = (a - b + 256) % 256;
      default: res = a ^ b;
    endcase
    @(negedge clk);
    op_valid = v; op_class = 3'(cls); alu_a = 8'(a); alu_b = 8'(b); alu_res = 8'(res);
    imask_set = ms; imask_clr = mc; restore_en = rs; restore_byte = 8'(rb);
    if (rs) begin
      m_h = (rb >> 4) & 1; m_i = (rb >> 3) & 1; m_n = (rb >> 2) & 1;
      m_z = (rb >> 1) & 1; m_c = rb & 1;
    end else begin
      if (v && cls <= 5) begin
        m_n = (res >= 128) ? 1 : 0;
        m_z = (res == 0) ? 1 : 0;
      end
      if (v && cls <= 1) begin
        tot = a + b + cin;
        m_h = ((a % 16) + (b % 16) + cin >= 16) ? 1 : 0;
        m_c = (tot >= 256) ? 1 : 0;
      end
      if (v && (cls == 4 || cls == 5)) m_c = (a < b) ? 1 : 0;
      if (ms) m_i = 1;
      else if (mc) m_i = 0;
    end
    @(negedge clk);
    op_valid = 1'b0; imask_set = 1'b0; imask_clr = 1'b0; restore_en = 1'b0;
    check(req, status_byte, model_byte());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2 power-on reset: I set, upper bits ones (R1)
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD/4);
    total++;
    if (status_byte[7:5] !== 3'b111 || status_byte[3] !== 1'b1) begin
      bad++;
      $display("FAIL R2: actual=%02h expected=111x1xxx", status_byte);
    end
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_i = 1;

    // R8 restore, R1 upper bits ignore the written value
    cyc("R8", 0, 0, 0, 0, 0, 0, 1, 8'h00);
    check("R1", status_byte, 8'hE0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1, 8'h1F);
    cyc("R1", 0, 0, 0, 0, 0, 0, 1, 8'hE0);
    cyc("R8", 0, 0, 0, 0, 0, 0, 1, 8'h15);

    // R5 additions at the nibble and byte boundaries
    cyc("R5", 1, 0, 8'h0F, 8'h01, 0, 0, 0, 0);
    cyc("R5", 1, 0, 8'hFF, 8'h01, 0, 0, 0, 0);
    cyc("R5", 1, 0, 8'h80, 8'h80, 0, 0, 0, 0);
    cyc("R5", 1, 1, 8'h0E, 8'h01, 0, 0, 0, 0);
    cyc("R5", 1, 1, 8'h12, 8'h34, 0, 0, 0, 0);
    cyc("R4", 1, 0, 8'h70, 8'h10, 0, 0, 0, 0);

    // R6 subtract and compare
    cyc("R6", 1, 4, 8'h05, 8'h06, 0, 0, 0, 0);
    cyc("R6", 1, 5, 8'h10, 8'h10, 0, 0, 0, 0);
    cyc("R6", 1, 4, 8'h90, 8'h10, 0, 0, 0, 0);

    // R7 logic and load keep C and H
    cyc("R8", 0, 0, 0, 0, 0, 0, 1, 8'h11);
    cyc("R7", 1, 2, 8'hF0, 8'h80, 0, 0, 0, 0);
    cyc("R7", 1, 3, 8'h00, 8'h00, 0, 0, 0, 0);

    // R3 reserved classes and idle cycles change nothing
    cyc("R3", 1, 6, 8'hFF, 8'h01, 0, 0, 0, 0);
    cyc("R3", 1, 7, 8'h00, 8'h00, 0, 0, 0, 0);
    cyc("R3", 0, 0, 8'hFF, 8'hFF, 0, 0, 0, 0);

    // R9 mask commands, set beats clear, ops do not touch I
    cyc("R9", 0, 0, 0, 0, 0, 1, 0, 0);
    cyc("R9", 1, 0, 8'h01, 8'h01, 0, 0, 0, 0);
    cyc("R9", 0, 0, 0, 0, 1, 1, 0, 0);
    cyc("R9", 1, 0, 8'h7F, 8'h01, 0, 1, 0, 0);

    // R8 restore wins over op and mask commands
    cyc("R8", 1, 0, 8'hFF, 8'hFF, 1, 0, 1, 8'hF2);
    cyc("R8", 1, 4, 8'h00, 8'h01, 0, 1, 1, 8'h1D);

    // R2 reset in mid-run: flags kept, I forced high immediately
    cyc("R2", 0, 0, 0, 0, 0, 1, 1, 8'h17);
    @(negedge clk);
    rst_n = 1'b0;
    m_i = 1;
    #(CLK_PERIOD/4);
    check("R2", status_byte, model_byte());
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    check("R2", status_byte, model_byte());

    // Mixed traffic compared every clock (R4 R5 R6 R7 R8 R9)
    for (int k = 0; k < 400; k++) begin
      int cls, rs, ms, mc;
      cls = int'($urandom_range(0, 7));
      rs  = ($urandom_range(0, 15) == 0) ? 1 : 0;
      ms  = ($urandom_range(0, 7) == 0) ? 1 : 0;
      mc  = ($urandom_range(0, 7) == 0) ? 1 : 0;
      cyc("R4_R9_mix", 1'($urandom_range(0, 1)), cls, int'($urandom_range(0, 255)),
          int'($urandom_range(0, 255)), 1'(ms), 1'(mc), 1'(rs), int'($urandom_range(0, 255)));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule